// File: doc/BRIEF.md
# Flag-Producing Integer ALU with Branch Condition Evaluator

This block is a 32-bit integer datapath stage. Each clock cycle it takes two operands and an operation select and registers one of five results: a sum, a difference, a logical left shift, a logical right shift or an arithmetic right shift. Add and subtract share a single adder. Subtraction feeds the adder the inverted second operand and a carry-in of one.

For add and subtract the block also derives four condition flags: negative, zero, signed overflow and carry/borrow. A small flag register keeps these flags between operations. The register loads only when flag update is enabled and the operation is an add or a subtract. In the same cycle, a 4-bit condition select is judged against the flags already held in the register. The verdict is registered as a branch-taken bit. This lets a compare in one cycle steer a branch decision in the next.

Top module: `alu_flag_core`

## Requirements
- R1: With op_sel = 0 (add), result is op_a + op_b modulo 2^32. C is the carry out of bit 31.
- R2: With op_sel = 1 (subtract), result is op_a + ~op_b + 1 modulo 2^32. C is reported as a borrow: it is 1 exactly when op_a < op_b as unsigned numbers.
- R3: After an add or subtract that updates the flags, V is 1 exactly when the true signed result lies outside -2^31 .. 2^31-1.
- R4: After an add or subtract that updates the flags, N equals result bit 31 and Z is 1 exactly when all 32 result bits are zero. The flags output is packed as {N, Z, V, C}, with N in bit 3 and C in bit 0.
- R5: op_sel = 2 shifts op_a left and op_sel = 3 shifts it right, both filling with zeros. op_sel = 4 shifts op_a right and fills the vacated bits with copies of op_a bit 31. The shift amount is op_b[4:0]; the higher bits of op_b are ignored.
- R6: Shift operations leave the flags unchanged, even when flag_we is 1.
- R7: When flag_we is 0, an add or subtract leaves the flags unchanged. The unused op_sel codes 5 to 7 produce a result of 0 and leave the flags unchanged.
- R8: Signed conditions on cond_sel: 3 less (N xor V), 4 less-or-equal (Z or (N xor V)), 5 greater-or-equal (not (N xor V)), 6 greater (not (Z or (N xor V))).
- R9: Unsigned conditions on cond_sel: 7 lower (C), 8 lower-or-same (C or Z), 9 higher-or-same (not C), 10 higher (not C and not Z).
- R10: Other conditions on cond_sel: 0 never, 1 equal (Z), 2 not-equal (not Z), 11 N set, 12 N clear, 13 V set, 14 V clear, 15 always.
- R11: result, flags and br_taken are registered and change at the clock edge that samples the inputs. br_taken judges cond_sel against the flags held before that same edge's update.
- R12: A synchronous active-high rst clears result, flags and br_taken to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | 32 | First operand; the value shifted by shift operations |
| op_b | input | 32 | Second operand; bits 4:0 give the shift amount |
| op_sel | input | 3 | Operation: 0 add, 1 subtract, 2 left shift, 3 logical right shift, 4 arithmetic right shift |
| flag_we | input | 1 | Flag update enable for add and subtract |
| cond_sel | input | 4 | Branch condition select |
| result | output | 32 | Registered operation result |
| flags | output | 4 | Flag register {N, Z, V, C} |
| br_taken | output | 1 | Registered branch verdict |

## Verification
The bench targets the operand corners 0, 1, -1, the most positive value and the most negative value. These are the places where a wrong overflow rule misses the positive-plus-one wrap or the negative-plus-negative wrap, and where an inverted-carry mistake makes a subtract with equal or reversed magnitudes report the wrong borrow. Shift amounts of 0 and 31, and an amount with high bits set, catch a shifter that fills with the wrong bit or reads too many amount bits. The bench sweeps all sixteen condition codes across eight reachable flag states, so a swapped signed and unsigned decode, or a missing Z term in the or-equal tests, shows up as a wrong verdict. Random add and subtract traffic with a condition judged in the same cycle exposes a design that evaluates against the freshly computed flags instead of the stored ones.

// File: rtl/alu_pkg.sv
package alu_pkg;

  localparam int DATA_W  = 32;
  localparam int SHAMT_W = $clog2(DATA_W);

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_SLL = 3'd2,
    OP_SRL = 3'd3,
    OP_SRA = 3'd4
  } alu_op_e;

  typedef enum logic [3:0] {
    CC_NEVER = 4'd0,
    CC_EQ    = 4'd1,
    CC_NE    = 4'd2,
    CC_SLT   = 4'd3,
    CC_SLE   = 4'd4,
    CC_SGE   = 4'd5,
    CC_SGT   = 4'd6,
    CC_ULT   = 4'd7,
    CC_ULE   = 4'd8,
    CC_UGE   = 4'd9,
    CC_UGT   = 4'd10,
    CC_NEG   = 4'd11,
    CC_POS   = 4'd12,
    CC_OVF   = 4'd13,
    CC_NOVF  = 4'd14,
    CC_ALWAYS = 4'd15
  } cond_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } flags_t;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub
  import alu_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] sum,
  output flags_t       fl
);

  logic [W-1:0] b_eff;
  logic [W:0]   full;

  always_comb begin
    b_eff = sub ? ~b : b;
    full  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};
    sum   = full[W-1:0];
    fl.n  = full[W-1];
    fl.z  = (full[W-1:0] == '0);
    // same-sign inputs to the adder producing a differently signed sum
    fl.v  = (a[W-1] == b_eff[W-1]) && (full[W-1] != a[W-1]);
    // subtract reports borrow rather than raw carry
    fl.c  = sub ? ~full[W] : full[W];
  end

endmodule

// File: rtl/alu_shifter.sv
module alu_shifter
  import alu_pkg::*;
#(
  parameter int W   = DATA_W,
  parameter int SHW = $clog2(W)
) (
  input  logic [W-1:0]   val,
  input  logic [SHW-1:0] amt,
  input  logic           left,
  input  logic           arith,
  output logic [W-1:0]   out
);

  logic [W-1:0] pre;
  logic [W-1:0] post;
  logic         fill;
  logic [W-1:0] stg [SHW+1];

  // left shifts reuse the right-shift stages on a bit-reversed operand
  for (genvar i = 0; i < W; i++) begin : g_rev
    assign pre[i] = left ? val[W-1-i]  : val[i];
    assign out[i] = left ? post[W-1-i] : post[i];
  end

  assign fill   = arith & ~left & val[W-1];
  assign stg[0] = pre;

  for (genvar k = 0; k < SHW; k++) begin : g_stage
    localparam int D = 1 << k;
    assign stg[k+1] = amt[k] ? {{D{fill}}, stg[k][W-1:D]} : stg[k];
  end

  assign post = stg[SHW];

endmodule

// File: rtl/alu_cond.sv
module alu_cond
  import alu_pkg::*;
(
  input  flags_t     fl,
  input  logic [3:0] sel,
  output logic       take
);

  logic lt_s;

  always_comb begin
    lt_s = fl.n ^ fl.v;
    unique case (sel)
      CC_NEVER:  take = 1'b0;
      CC_EQ:     take = fl.z;
      CC_NE:     take = ~fl.z;
      CC_SLT:    take = lt_s;
      CC_SLE:    take = fl.z | lt_s;
      CC_SGE:    take = ~lt_s;
      CC_SGT:    take = ~(fl.z | lt_s);
      CC_ULT:    take = fl.c;
      CC_ULE:    take = fl.c | fl.z;
      CC_UGE:    take = ~fl.c;
      CC_UGT:    take = ~fl.c & ~fl.z;
      CC_NEG:    take = fl.n;
      CC_POS:    take = ~fl.n;
      CC_OVF:    take = fl.v;
      CC_NOVF:   take = ~fl.v;
      default:   take = 1'b1;
    endcase
  end

endmodule

// File: rtl/alu_flag_core.sv
module alu_flag_core
  import alu_pkg::*;
#(
  parameter int W   = DATA_W,
  parameter int SHW = $clog2(W)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [2:0]   op_sel,
  input  logic         flag_we,
  input  logic [3:0]   cond_sel,
  output logic [W-1:0] result,
  output logic [3:0]   flags,
  output logic         br_taken
);

  logic [W-1:0] sum;
  logic [W-1:0] shv;
  flags_t       fl_new;
  flags_t       fl_q;
  logic         take_d;
  logic         is_arith;
  logic         is_shift;
  logic [W-1:0] res_d;
  logic [W-1:0] res_q;
  logic         take_q;

  assign is_arith = (op_sel == OP_ADD) || (op_sel == OP_SUB);
  assign is_shift = (op_sel == OP_SLL) || (op_sel == OP_SRL) || (op_sel == OP_SRA);

  alu_addsub #(.W(W)) u_addsub (
    .a   (op_a),
    .b   (op_b),
    .sub (op_sel == OP_SUB),
    .sum (sum),
    .fl  (fl_new)
  );

  alu_shifter #(.W(W), .SHW(SHW)) u_shift (
    .val   (op_a),
    .amt   (op_b[SHW-1:0]),
    .left  (op_sel == OP_SLL),
    .arith (op_sel == OP_SRA),
    .out   (shv)
  );

  alu_cond u_cond (
    .fl   (fl_q),
    .sel  (cond_sel),
    .take (take_d)
  );

  always_comb begin
    if (is_arith)      res_d = sum;
    else if (is_shift) res_d = shv;
    else               res_d = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q  <= '0;
      fl_q   <= '0;
      take_q <= 1'b0;
    end else begin
      res_q  <= res_d;
      take_q <= take_d;
      if (flag_we && is_arith) fl_q <= fl_new;
    end
  end

  assign result   = res_q;
  assign flags    = fl_q;
  assign br_taken = take_q;

  a_r12_reset_clears: assert property (@(posedge clk)
    rst |=> (res_q == '0 && fl_q == '0 && !take_q));

  a_r6_shift_keeps_flags: assert property (@(posedge clk) disable iff (rst)
    is_shift |=> $stable(fl_q));

  a_r7_we_low_keeps_flags: assert property (@(posedge clk) disable iff (rst)
    !flag_we |=> $stable(fl_q));

  a_r4_zero_matches_result: assert property (@(posedge clk) disable iff (rst)
    (flag_we && is_arith) |=> (fl_q.z == (res_q == '0)) && (fl_q.n == res_q[W-1]));

  a_r2_borrow_is_unsigned_lt: assert property (@(posedge clk) disable iff (rst)
    (flag_we && op_sel == OP_SUB) |=> (fl_q.c == ($past(op_a) < $past(op_b))));

  a_r11_eq_uses_stored_z: assert property (@(posedge clk) disable iff (rst)
    (cond_sel == CC_EQ) |=> (take_q == $past(fl_q.z)));

endmodule

// File: tb/test_alu_flag_core.sv
module test_alu_flag_core;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic [2:0]  op_sel = '0;
  logic        flag_we = 1'b0;
  logic [3:0]  cond_sel = '0;
  logic [31:0] result;
  logic [3:0]  flags;
  logic        br_taken;

  int total = 0;
  int errs  = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  alu_flag_core i_alu_flag_core (
    .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .op_sel(op_sel),
    .flag_we(flag_we), .cond_sel(cond_sel), .result(result),
    .flags(flags), .br_taken(br_taken)
  );

  // {op, a, b, expected result, expected flags NZVC}
  localparam int NV = 16;
  localparam logic [102:0] VEC [NV] = '{
    {3'd0, 32'h00000001, 32'hFFFFFFFF, 32'h00000000, 4'b0101},
    {3'd0, 32'h7FFFFFFF, 32'h00000001, 32'h80000000, 4'b1010},
    {3'd0, 32'h80000000, 32'h80000000, 32'h00000000, 4'b0111},
    {3'd1, 32'h00000005, 32'h00000003, 32'h00000002, 4'b0000},
    {3'd1, 32'h00000003, 32'h00000005, 32'hFFFFFFFE, 4'b1001},
    {3'd1, 32'h80000000, 32'h00000001, 32'h7FFFFFFF, 4'b0010},
    {3'd1, 32'h00000000, 32'h00000000, 32'h00000000, 4'b0100},
    {3'd1, 32'h7FFFFFFF, 32'hFFFFFFFF, 32'h80000000, 4'b1011},
    {3'd2, 32'h00000001, 32'h0000001F, 32'h80000000, 4'b1011},
    {3'd3, 32'h80000000, 32'h0000001F, 32'h00000001, 4'b1011},
    {3'd4, 32'h80000000, 32'h0000001F, 32'hFFFFFFFF, 4'b1011},
    {3'd4, 32'h7FFFFFF0, 32'h00000004, 32'h07FFFFFF, 4'b1011},
    {3'd2, 32'h12345678, 32'h00000000, 32'h12345678, 4'b1011},
    {3'd3, 32'hF0000000, 32'h00000004, 32'h0F000000, 4'b1011},
    {3'd2, 32'h0000000F, 32'h00000024, 32'h000000F0, 4'b1011},
    {3'd0, 32'h00000002, 32'hFFFFFFFE, 32'h00000000, 4'b0101}
  };

  // flag states reachable by add/sub, with an operation that produces each
  localparam logic [70:0] FSET [8] = '{
    {3'd1, 32'h00000005, 32'h00000003, 4'b0000},
    {3'd0, 32'h00000001, 32'hFFFFFFFF, 4'b0101},
    {3'd0, 32'h7FFFFFFF, 32'h00000001, 4'b1010},
    {3'd0, 32'h80000000, 32'h80000000, 4'b0111},
    {3'd1, 32'h00000003, 32'h00000005, 4'b1001},
    {3'd1, 32'h80000000, 32'h00000001, 4'b0010},
    {3'd1, 32'h00000000, 32'h00000000, 4'b0100},
    {3'd1, 32'h7FFFFFFF, 32'hFFFFFFFF, 4'b1011}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                     input logic we, input logic [3:0] cs);
    op_sel = op; op_a = a; op_b = b; flag_we = we; cond_sel = cs;
    @(negedge clk);
  endtask

  // expected verdict written from the condition table in the requirements
  function automatic logic want(input logic [3:0] f, input logic [3:0] cs);
    logic n, z, v, c;
    {n, z, v, c} = f;
    case (cs)
      4'd0:  return 1'b0;
      4'd1:  return z;
      4'd2:  return !z;
      4'd3:  return n != v;
      4'd4:  return z || (n != v);
      4'd5:  return n == v;
      4'd6:  return !z && (n == v);
      4'd7:  return c;
      4'd8:  return c || z;
      4'd9:  return !c;
      4'd10: return !c && !z;
      4'd11: return n;
      4'd12: return !n;
      4'd13: return v;
      4'd14: return !v;
      default: return 1'b1;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; errs++;
      $display("FAIL R11 watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", total - errs, total);
      $finish;
    end
  end

  initial begin
    logic [3:0] mf;
    @(negedge clk); @(negedge clk);
    // R12 reset state
    chk("R12 result after reset", result, 32'h0);
    chk("R12 flags after reset", {28'h0, flags}, 32'h0);
    chk("R12 br_taken after reset", {31'h0, br_taken}, 32'h0);
    rst = 1'b0;

    // vector table: R1 R2 R3 R4 R5 R6
    for (int i = 0; i < NV; i++) begin
      cyc(VEC[i][102:100], VEC[i][99:68], VEC[i][67:36], 1'b1, 4'd0);
      chk($sformatf("R1/R2/R5 result vec %0d", i), result, VEC[i][35:4]);
      chk($sformatf("R3/R4/R6 flags vec %0d", i), {28'h0, flags}, {28'h0, VEC[i][3:0]});
    end

    // R7 flag_we low keeps flags (currently 0101)
    cyc(3'd1, 32'h3, 32'h5, 1'b0, 4'd0);
    chk("R7 result with we low", result, 32'hFFFFFFFE);
    chk("R7 flags held with we low", {28'h0, flags}, 32'h5);
    // R7 unused op codes
    for (int k = 5; k < 8; k++) begin
      cyc(3'(k), 32'hFFFFFFFF, 32'h1, 1'b1, 4'd0);
      chk($sformatf("R7 result for op %0d", k), result, 32'h0);
      chk($sformatf("R7 flags for op %0d", k), {28'h0, flags}, 32'h5);
    end

    // R8 R9 R10 every condition against every reachable flag state
    for (int s = 0; s < 8; s++) begin
      for (int cs = 0; cs < 16; cs++) begin
        cyc(FSET[s][70:68], FSET[s][67:36], FSET[s][35:4], 1'b1, 4'd0);
        cyc(3'd3, 32'h0, 32'h0, 1'b1, 4'(cs));
        chk($sformatf("R8/R9/R10 cond %0d flags %b", cs, FSET[s][3:0]),
            {31'h0, br_taken}, {31'h0, want(FSET[s][3:0], 4'(cs))});
      end
    end

    // R11 random add/sub with a condition judged in the same cycle
    mf = flags;
    for (int r = 0; r < 300; r++) begin
      logic [31:0] a, b, er;
      logic [3:0]  cs, ef;
      logic        sub, cf, vf;
      longint      sr;
      a = $urandom; b = $urandom; sub = 1'($urandom); cs = 4'($urandom);
      if (r % 5 == 0) a = (r % 10 == 0) ? 32'h80000000 : 32'h7FFFFFFF;
      if (r % 7 == 0) b = (r % 14 == 0) ? 32'hFFFFFFFF : 32'h00000001;
      if (sub) begin
        er = a - b; cf = (a < b);
        sr = longint'($signed(a)) - longint'($signed(b));
      end else begin
        er = a + b; cf = ({1'b0, a} + {1'b0, b}) > 33'hFFFFFFFF;
        sr = longint'($signed(a)) + longint'($signed(b));
      end
      vf = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
      ef = {er[31], er == 32'h0, vf, cf};
      cyc({2'b00, sub}, a, b, 1'b1, cs);
      chk("R1/R2 random result", result, er);
      chk("R3/R4 random flags", {28'h0, flags}, {28'h0, ef});
      chk("R11 verdict on stored flags", {31'h0, br_taken}, {31'h0, want(mf, cs)});
      mf = ef;
    end

    // R12 reset in mid-run
    cyc(3'd0, 32'h7FFFFFFF, 32'h1, 1'b1, 4'd15);
    rst = 1'b1;
    @(negedge clk);
    chk("R12 result cleared mid-run", result, 32'h0);
    chk("R12 flags cleared mid-run", {28'h0, flags}, 32'h0);
    chk("R12 br_taken cleared mid-run", {31'h0, br_taken}, 32'h0);
    rst = 1'b0;

    done = 1;
    $display("%0d/%0d checks passed", total - errs, total);
    $finish;
  end

endmodule